// File: doc/BRIEF.md
# TLB Management Register Interface

This block is the software-facing side of a translation lookaside buffer. Software cannot reach the entries directly. It programs an index register and then reads or writes the high and low words of the selected entry through two window registers. A process-identifier register and a zone-protection register sit beside them. A search register sends an address to the translation datapath, which is a separate block, and the result comes back into the index register.

The entry storage lives outside this block. The block drives an entry write port and receives the selected entry's two words and its stored translation ID. Whenever cached translations go stale, it tells the rest of the memory system with a one-cycle flush request. Two configuration inputs set whether translation hardware exists and how much software access it grants. When an access is refused, the block raises a one-cycle illegal-access flag. While a search is outstanding, the register port reports busy.

Top module: `tlb_mgmt_regs`

## Requirements
- R1: When `cfg_mmu_level` is below 2 or `cfg_sw_access` is 0, every register access is ignored, `reg_rdata` is 0 and the access is refused.
- R2: The `reg_sel` codes are 0 entry-low, 1 entry-high, 2 zone protection, 3 process ID, 4 index and 5 search. Entry-low and entry-high accesses address the entry given by the low bits of the index register (`ent_idx`). Codes 6 and 7, and reads of the search code, return 0, change nothing and are not refused.
- R3: A read of the entry-high window loads the process-ID register with the entry's stored 8-bit translation ID, zero-extended.
- R4: A write to the entry-high window stores the process ID's low 8 bits as the entry's translation ID (`ent_wtid`). The following cycle it raises `flush_req` with `flush_kind` 0 (single entry) and `flush_idx` equal to the entry index.
- R5: Reads of entry-low, entry-high and index are refused, and return 0, unless bit 0 of `cfg_sw_access` is set.
- R6: Writes to zone protection, process ID and search are refused when `cfg_sw_access` is 1 or less.
- R7: A zone-protection write of a new value raises `flush_req` with `flush_kind` 1 (all entries). Writing the value already held raises no flush.
- R8: A process-ID write of a new value raises `flush_req` with `flush_kind` 2 (by ID) and `flush_tid` equal to the old process ID's low 8 bits. Entries whose nonzero translation ID matches that value are the ones to be flushed.
- R9: A refused access pulses `reg_illegal` for one cycle, the cycle after the access, and leaves the index, process-ID and zone registers unchanged.
- R10: A search write raises `lk_req` with `lk_vaddr` equal to the written value with bits below 10 cleared. `reg_busy` is held until `lk_rsp_valid`. The index register then receives `lk_idx`, with bit 31 set when `lk_hit` is 0.
- R11: Register accesses presented while `reg_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mmu_level | input | 2 | Translation hardware configuration level |
| cfg_sw_access | input | 2 | Software access grant |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| reg_busy | output | 1 | Search outstanding, port stalled |
| reg_illegal | output | 1 | One-cycle refused-access flag |
| ent_idx | output | log2(NUM_ENTRIES) | Selected entry index |
| ent_rd_lo | input | 32 | Low word of selected entry |
| ent_rd_hi | input | 32 | High word of selected entry |
| ent_rd_tid | input | 8 | Stored translation ID of selected entry |
| ent_we | output | 1 | Entry write enable |
| ent_we_hi | output | 1 | 1 = high word (and ID), 0 = low word |
| ent_wdata | output | 32 | Entry write data |
| ent_wtid | output | 8 | Translation ID written with the high word |
| lk_req | output | 1 | Lookup request to the translation datapath |
| lk_vaddr | output | 32 | Page address to look up |
| lk_rsp_valid | input | 1 | Lookup response strobe |
| lk_hit | input | 1 | Lookup hit |
| lk_idx | input | log2(NUM_ENTRIES) | Matching entry index |
| flush_req | output | 1 | One-cycle flush request |
| flush_kind | output | 2 | 0 entry, 1 all, 2 by ID |
| flush_idx | output | log2(NUM_ENTRIES) | Entry for a single-entry flush |
| flush_tid | output | 8 | ID for a by-ID flush |

## Verification
On every cycle, the assertions check that a refused access leaves the registers untouched and that a disabled configuration produces no entry writes and no read data. They also check that a flush only follows a write, that nothing reaches the entry port while busy, and that a lookup response ends busy with the correct miss bit. Other behaviour needs the bench's scenarios against its reference model. That covers the ID loaded by a high-window read, the ID carried by a high-window write, the choice between flushing and not flushing on equal or changed values, and the refusal matrix across access settings.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
    typedef enum logic [2:0] {
        SEL_ENT_LO = 3'd0,
        SEL_ENT_HI = 3'd1,
        SEL_ZONE   = 3'd2,
        SEL_PID    = 3'd3,
        SEL_INDEX  = 3'd4,
        SEL_SEARCH = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        FL_ENTRY = 2'd0,
        FL_ALL   = 2'd1,
        FL_TID   = 2'd2
    } flush_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } port_state_e;
endpackage

// File: rtl/tlbm_access_check.sv
module tlbm_access_check
    import tlbm_pkg::*;
(
    input  logic [1:0] cfg_mmu_level,
    input  logic [1:0] cfg_sw_access,
    input  logic       acc_write,
    input  logic [2:0] acc_sel,
    output logic       acc_present,
    output logic       acc_allowed,
    output logic       acc_refused
);
    logic wide_grant;

    always_comb begin
        acc_present = (cfg_mmu_level >= 2'd2) && (cfg_sw_access != 2'd0);
        wide_grant  = (cfg_sw_access >= 2'd2);
        acc_allowed = 1'b0;
        acc_refused = 1'b0;
        if (!acc_present) begin
            acc_refused = 1'b1;
        end else begin
            case (acc_sel)
                SEL_ENT_LO, SEL_ENT_HI, SEL_INDEX: begin
                    acc_allowed = acc_write || cfg_sw_access[0];
                    acc_refused = !acc_allowed;
                end
                SEL_ZONE, SEL_PID, SEL_SEARCH: begin
                    acc_allowed = !acc_write || wide_grant;
                    acc_refused = !acc_allowed;
                end
                default: begin
                    acc_allowed = 1'b0;
                    acc_refused = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/tlb_mgmt_regs.sv
module tlb_mgmt_regs
    import tlbm_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int EPN_LSB     = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     cfg_mmu_level,
    input  logic [1:0]                     cfg_sw_access,
    input  logic                           reg_valid,
    input  logic                           reg_write,
    input  logic [2:0]                     reg_sel,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    output logic                           reg_busy,
    output logic                           reg_illegal,
    output logic [$clog2(NUM_ENTRIES)-1:0] ent_idx,
    input  logic [31:0]                    ent_rd_lo,
    input  logic [31:0]                    ent_rd_hi,
    input  logic [7:0]                     ent_rd_tid,
    output logic                           ent_we,
    output logic                           ent_we_hi,
    output logic [31:0]                    ent_wdata,
    output logic [7:0]                     ent_wtid,
    output logic                           lk_req,
    output logic [31:0]                    lk_vaddr,
    input  logic                           lk_rsp_valid,
    input  logic                           lk_hit,
    input  logic [$clog2(NUM_ENTRIES)-1:0] lk_idx,
    output logic                           flush_req,
    output logic [1:0]                     flush_kind,
    output logic [$clog2(NUM_ENTRIES)-1:0] flush_idx,
    output logic [7:0]                     flush_tid
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int PAD_W = 31 - IDX_W;

    typedef struct packed {
        port_state_e       st;
        logic [31:0]       tlbx;
        logic [31:0]       pid;
        logic [31:0]       zpr;
        logic              illegal;
        logic              flush;
        flush_kind_e       fkind;
        logic [IDX_W-1:0]  fidx;
        logic [7:0]        ftid;
        logic [31:0]       vaddr;
    } regs_t;

    regs_t r_d, r_q;

    logic acc_present, acc_allowed, acc_refused;
    logic go, do_ok, do_bad;

    tlbm_access_check u_access (
        .cfg_mmu_level (cfg_mmu_level),
        .cfg_sw_access (cfg_sw_access),
        .acc_write     (reg_write),
        .acc_sel       (reg_sel),
        .acc_present   (acc_present),
        .acc_allowed   (acc_allowed),
        .acc_refused   (acc_refused)
    );

    assign go     = reg_valid && (r_q.st == ST_IDLE);
    assign do_ok  = go && acc_allowed;
    assign do_bad = go && acc_refused;

    always_comb begin
        r_d         = r_q;
        r_d.illegal = do_bad;
        r_d.flush   = 1'b0;
        if (do_ok && reg_write) begin
            case (reg_sel)
                SEL_ENT_HI: begin
                    r_d.flush = 1'b1;
                    r_d.fkind = FL_ENTRY;
                    r_d.fidx  = r_q.tlbx[IDX_W-1:0];
                end
                SEL_ZONE: begin
                    if (reg_wdata != r_q.zpr) begin
                        r_d.flush = 1'b1;
                        r_d.fkind = FL_ALL;
                    end
                    r_d.zpr = reg_wdata;
                end
                SEL_PID: begin
                    if (reg_wdata != r_q.pid) begin
                        r_d.flush = 1'b1;
                        r_d.fkind = FL_TID;
                        r_d.ftid  = r_q.pid[7:0];
                    end
                    r_d.pid = reg_wdata;
                end
                SEL_INDEX: r_d.tlbx = reg_wdata;
                SEL_SEARCH: begin
                    r_d.st    = ST_WAIT;
                    r_d.vaddr = {reg_wdata[31:EPN_LSB], {EPN_LSB{1'b0}}};
                end
                default: ;
            endcase
        end
        if (do_ok && !reg_write && (reg_sel == SEL_ENT_HI)) begin
            r_d.pid = {24'd0, ent_rd_tid};
        end
        if ((r_q.st == ST_WAIT) && lk_rsp_valid) begin
            r_d.st   = ST_IDLE;
            r_d.tlbx = {!lk_hit, {PAD_W{1'b0}}, lk_idx};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = 32'd0;
        if (do_ok && !reg_write) begin
            case (reg_sel)
                SEL_ENT_LO: reg_rdata = ent_rd_lo;
                SEL_ENT_HI: reg_rdata = ent_rd_hi;
                SEL_ZONE:   reg_rdata = r_q.zpr;
                SEL_PID:    reg_rdata = r_q.pid;
                SEL_INDEX:  reg_rdata = r_q.tlbx;
                default:    reg_rdata = 32'd0;
            endcase
        end
    end

    assign ent_idx     = r_q.tlbx[IDX_W-1:0];
    assign ent_we      = do_ok && reg_write &&
                         ((reg_sel == SEL_ENT_LO) || (reg_sel == SEL_ENT_HI));
    assign ent_we_hi   = (reg_sel == SEL_ENT_HI);
    assign ent_wdata   = reg_wdata;
    assign ent_wtid    = r_q.pid[7:0];
    assign reg_busy    = (r_q.st == ST_WAIT);
    assign reg_illegal = r_q.illegal;
    assign lk_req      = (r_q.st == ST_WAIT);
    assign lk_vaddr    = r_q.vaddr;
    assign flush_req   = r_q.flush;
    assign flush_kind  = r_q.fkind;
    assign flush_idx   = r_q.fidx;
    assign flush_tid   = r_q.ftid;

    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_present) |-> (!ent_we && (reg_rdata == 32'd0)));

    assert_flush_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> $past(reg_valid && reg_write));

    assert_refused_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_illegal |-> ($stable(r_q.pid) && $stable(r_q.zpr) && $stable(r_q.tlbx)));

    assert_miss_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_busy && lk_rsp_valid) |=> (!reg_busy && (r_q.tlbx[31] == !$past(lk_hit))));

    assert_busy_blocks_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_busy |-> (!ent_we && (reg_rdata == 32'd0) && !$rose(reg_illegal)));
endmodule

// File: tb/tlb_mgmt_regs_tb.sv
module tlb_mgmt_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NENT = 64;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_mmu_level = 2'd3, cfg_sw_access = 2'd3;
    logic reg_valid = 1'b0, reg_write = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic reg_busy, reg_illegal;
    logic [IW-1:0] ent_idx;
    logic [31:0] ent_rd_lo, ent_rd_hi;
    logic [7:0] ent_rd_tid;
    logic ent_we, ent_we_hi;
    logic [31:0] ent_wdata;
    logic [7:0] ent_wtid;
    logic lk_req;
    logic [31:0] lk_vaddr;
    logic lk_rsp_valid = 1'b0, lk_hit = 1'b0;
    logic [IW-1:0] lk_idx = '0;
    logic flush_req;
    logic [1:0] flush_kind;
    logic [IW-1:0] flush_idx;
    logic [7:0] flush_tid;

    logic [31:0] ram_lo [NENT];
    logic [31:0] ram_hi [NENT];
    logic [7:0]  ram_tid [NENT];

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_pid = 0, m_zpr = 0, m_tlbx = 0;
    logic exp_illegal = 0, exp_flush = 0, exp_busy = 0;
    logic [1:0] exp_fkind = 0;
    logic [IW-1:0] exp_fidx = 0;
    logic [7:0] exp_ftid = 0;
    string exp_tag = "R4";

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_mgmt_regs #(.NUM_ENTRIES(NENT), .EPN_LSB(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mmu_level(cfg_mmu_level), .cfg_sw_access(cfg_sw_access),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_busy(reg_busy), .reg_illegal(reg_illegal),
        .ent_idx(ent_idx), .ent_rd_lo(ent_rd_lo), .ent_rd_hi(ent_rd_hi), .ent_rd_tid(ent_rd_tid),
        .ent_we(ent_we), .ent_we_hi(ent_we_hi), .ent_wdata(ent_wdata), .ent_wtid(ent_wtid),
        .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit),
        .lk_idx(lk_idx), .flush_req(flush_req), .flush_kind(flush_kind),
        .flush_idx(flush_idx), .flush_tid(flush_tid)
    );

    // Entry storage stands outside the block; the bench plays that role.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                ram_lo[i] <= 32'd0; ram_hi[i] <= 32'd0; ram_tid[i] <= 8'd0;
            end
        end else if (ent_we) begin
            if (ent_we_hi) begin
                ram_hi[ent_idx] <= ent_wdata;
                ram_tid[ent_idx] <= ent_wtid;
            end else begin
                ram_lo[ent_idx] <= ent_wdata;
            end
        end
    end
    assign ent_rd_lo  = ram_lo[ent_idx];
    assign ent_rd_hi  = ram_hi[ent_idx];
    assign ent_rd_tid = ram_tid[ent_idx];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of the registered outputs against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(reg_illegal == exp_illegal, "R9 illegal", {31'd0, reg_illegal}, {31'd0, exp_illegal});
            chk(flush_req == exp_flush, exp_tag, {31'd0, flush_req}, {31'd0, exp_flush});
            chk(reg_busy == exp_busy, "R10 busy", {31'd0, reg_busy}, {31'd0, exp_busy});
            if (exp_flush && flush_req) begin
                chk(flush_kind == exp_fkind, exp_tag, {30'd0, flush_kind}, {30'd0, exp_fkind});
                if (exp_fkind == 2'd0)
                    chk(flush_idx == exp_fidx, "R4 idx", {26'd0, flush_idx}, {26'd0, exp_fidx});
                if (exp_fkind == 2'd2)
                    chk(flush_tid == exp_ftid, "R8 tid", {24'd0, flush_tid}, {24'd0, exp_ftid});
            end
        end
    end

    task automatic acc(input logic wr, input logic [2:0] sel, input logic [31:0] wd);
        logic present, ok, bad, fl;
        logic [31:0] exp_rd;
        logic [IW-1:0] ix;
        present = (cfg_mmu_level >= 2) && (cfg_sw_access != 0);
        ix = m_tlbx[IW-1:0];
        ok = 0; bad = 0;
        if (exp_busy) begin ok = 0; bad = 0; end                  // R11
        else if (!present) bad = 1;                                // R1
        else if (sel <= 1 || sel == 4) begin ok = wr || cfg_sw_access[0]; bad = !ok; end // R5
        else if (sel <= 5) begin ok = !wr || (cfg_sw_access >= 2); bad = !ok; end        // R6
        exp_rd = 0;
        if (ok && !wr) begin
            case (sel)
                3'd0: exp_rd = ram_lo[ix];
                3'd1: exp_rd = ram_hi[ix];
                3'd2: exp_rd = m_zpr;
                3'd3: exp_rd = m_pid;
                3'd4: exp_rd = m_tlbx;
                default: exp_rd = 0;                                // R2
            endcase
        end
        @(posedge clk); #1;
        reg_valid = 1; reg_write = wr; reg_sel = sel; reg_wdata = wd;
        #3;
        chk(reg_rdata == exp_rd, "R2 rdata", reg_rdata, exp_rd);
        chk(ent_we == (ok && wr && sel <= 1), "R2 ent_we", {31'd0, ent_we}, {31'd0, ok && wr && sel <= 1});
        if (ok && wr && sel <= 1) begin
            chk(ent_idx == ix, "R2 ent_idx", {26'd0, ent_idx}, {26'd0, ix});
            if (sel == 1) chk(ent_wtid == m_pid[7:0], "R4 tid", {24'd0, ent_wtid}, {24'd0, m_pid[7:0]});
        end
        @(posedge clk); #1;
        reg_valid = 0; reg_write = 0;
        exp_illegal = bad;
        fl = 0;
        if (ok && wr) begin
            case (sel)
                3'd1: begin fl = 1; exp_fkind = 0; exp_fidx = ix; exp_tag = "R4 flush"; end
                3'd2: begin
                    if (wd != m_zpr) begin fl = 1; exp_fkind = 1; end
                    exp_tag = "R7 flush"; m_zpr = wd;
                end
                3'd3: begin
                    if (wd != m_pid) begin fl = 1; exp_fkind = 2; exp_ftid = m_pid[7:0]; end
                    exp_tag = "R8 flush"; m_pid = wd;
                end
                3'd4: m_tlbx = wd;
                3'd5: exp_busy = 1;
                default: ;
            endcase
        end
        if (ok && !wr && sel == 1) m_pid = {24'd0, ram_tid[ix]};    // R3
        exp_flush = fl;
        @(posedge clk); #1;
        exp_illegal = 0; exp_flush = 0;
    endtask

    task automatic respond(input logic hit, input logic [IW-1:0] idx, input logic [31:0] exp_va);
        @(posedge clk); #1;
        chk(lk_req == 1'b1, "R10 lk_req", {31'd0, lk_req}, 32'd1);
        chk(lk_vaddr == exp_va, "R10 lk_vaddr", lk_vaddr, exp_va);
        lk_rsp_valid = 1; lk_hit = hit; lk_idx = idx;
        @(posedge clk); #1;
        lk_rsp_valid = 0;
        exp_busy = 0;
        m_tlbx = {!hit, 25'd0, idx};
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(reg_busy == 0 && reg_illegal == 0 && flush_req == 0, "reset R9", {29'd0, reg_busy, reg_illegal, flush_req}, 0);
        acc(0, 3'd3, 0);                    // R2 reset PID reads 0
        acc(1, 3'd4, 32'd5);                // index -> 5
        acc(1, 3'd0, 32'h1111_2222);        // R2 low word
        acc(1, 3'd3, 32'h0000_002A);        // R8 PID change from 0
        acc(1, 3'd1, 32'hABCD_E000);        // R4 high word with ID 0x2A
        acc(0, 3'd0, 0);
        acc(0, 3'd1, 0);                    // R3 loads PID 0x2A
        acc(0, 3'd4, 0);
        acc(1, 3'd3, 32'h0000_002A);        // R8 equal value, no flush
        acc(1, 3'd3, 32'h0000_0033);        // R8 flush ID 0x2A
        acc(0, 3'd1, 0);                    // R3 PID back to 0x2A
        acc(0, 3'd3, 0);
        acc(1, 3'd2, 32'h5555_0000);        // R7 flush all
        acc(1, 3'd2, 32'h5555_0000);        // R7 equal, no flush
        acc(0, 3'd2, 0);
        acc(1, 3'd5, 32'h1234_5FFF);        // R10 search
        acc(1, 3'd3, 32'h0000_0077);        // R11 ignored while busy
        respond(1, 6'd9, 32'h1234_5C00);
        acc(0, 3'd4, 0);                    // R10 hit -> 9
        acc(0, 3'd3, 0);                    // R11 PID unchanged
        acc(1, 3'd5, 32'h0000_03FF);
        respond(0, 6'd3, 32'h0000_0000);
        acc(0, 3'd4, 0);                    // R10 miss -> bit 31
        acc(1, 3'd4, 32'h0000_0107);        // R2 low bits select entry 7
        acc(1, 3'd0, 32'hCAFE_0007);
        acc(0, 3'd0, 0);
        cfg_sw_access = 2'd1;
        acc(1, 3'd3, 32'h0000_0099);        // R6 refused
        acc(1, 3'd2, 32'h0000_0001);        // R6 refused
        acc(1, 3'd5, 32'h0000_0000);        // R6 refused
        acc(0, 3'd3, 0);
        acc(0, 3'd4, 0);
        cfg_sw_access = 2'd2;
        acc(0, 3'd0, 0);                    // R5 refused
        acc(0, 3'd4, 0);                    // R5 refused
        acc(1, 3'd1, 32'h0BAD_F000);        // R4 write still allowed
        acc(1, 3'd2, 32'h0000_0003);        // R7
        cfg_sw_access = 2'd3;
        cfg_mmu_level = 2'd1;
        acc(0, 3'd3, 0);                    // R1 reads 0, refused
        acc(1, 3'd4, 32'h0000_0001);        // R1 ignored
        acc(1, 3'd0, 32'hFFFF_FFFF);        // R1 no entry write
        cfg_mmu_level = 2'd3; cfg_sw_access = 2'd0;
        acc(0, 3'd2, 0);                    // R1 access setting 0
        cfg_sw_access = 2'd3;
        acc(0, 3'd4, 0);                    // R1 index unchanged
        acc(0, 3'd1, 0);                    // R3
        acc(0, 3'd6, 0);                    // R2 unused code
        acc(1, 3'd7, 32'h1234_5678);        // R2 unused write, not refused
        acc(0, 3'd5, 0);                    // R2 search reads 0
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule